// File: doc/BRIEF.md
# Cache Test Address Generator

This block walks a cache controller through a fixed sequence of test addresses. Each address is chosen so that, over the full run, every tag bit, every set index and every word slot within a line gets exercised, and no two addresses in one run land on the same location. A processor-side test routine, or a small bus master, pulses `start_i` once. It then raises `step_i` each time it has used the address currently shown on `addr_o`. When the whole sequence has been handed out, `done_o` goes high.

The address has four parts that are added together: a base address, a tag term, a set-index term and a byte-offset term. The geometry comes from five parameters: base address, cache size, line size, word size and the size of cacheable memory. From these the block derives the number of lines, the words per line and the tag width. The tag term is a rotating pattern. In data mode it is one-hot. In instruction mode it is one-cold. The pattern rotates as the line counter advances. The word offset is skewed by the line number, so consecutive lines touch different word slots.

The mode is captured when the run starts. The run has two counters. The line counter is the inner one and steps on every accepted strobe. The word counter is the outer one and steps each time the line counter wraps.

Top module: `cache_test_addr_gen`

## Requirements
- R1: Geometry is derived from the parameters: lines = cache size / line size, words per line = line size / word size, tag width = log2(memory size) - log2(cache size). With an 8 KB cache, 16 B lines, 4 B words and 256 KB memory, this gives 512 lines, 4 words and a 5-bit tag, and the second address of a data-mode run is base + 0x4014.
- R2: `addr_o` = base + (tag << log2(cache size)) + (m << log2(line size)) + (word offset << log2(word size)), where m is the line counter and n is the word counter.
- R3: In data mode (`mode_i` = 0 at start), the tag field has exactly one bit at 1, at position m mod tag width.
- R4: In instruction mode (`mode_i` = 1 at start), the tag field has exactly one bit at 0, at position m mod tag width. All other tag bits are 1.
- R5: The set-index field of `addr_o` (the bits just above the line offset) equals m.
- R6: The word offset equals (m + n) mod words-per-line.
- R7: Each accepted step increments m. When m wraps from lines-1 to 0, n increments instead of staying put.
- R8: A run yields exactly lines × words-per-line addresses. `done_o` rises in the cycle after the step that retires the last address, and both counters return to 0.
- R9: A `start_i` pulse zeroes both counters and clears `done_o` on the next edge. If `step_i` is high in the same cycle, `start_i` wins.
- R10: While `done_o` is high, `step_i` has no effect: `addr_o` and `done_o` hold.
- R11: After reset, `done_o` is 1, both counters are 0 and the mode is data mode, so `addr_o` = base + 0x2000 for the default geometry.
- R12: The mode is latched only on `start_i`. Changing `mode_i` during a run leaves the tag pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new run; zeroes counters and captures the mode |
| step_i | input | 1 | Advance to the next address |
| mode_i | input | 1 | 0 = data (one-hot tag), 1 = instruction (one-cold tag) |
| addr_o | output | ADDR_W | Current test address |
| done_o | output | 1 | High once the full sequence has been produced, and after reset |

## Verification
The hardest situations to reach from the ports are the word-counter rollover at the very end of a run, and a restart that arrives together with a step in the middle of a run. The stimulus drives complete runs of 2048 accepted steps in both modes. Step gaps and a toggling mode input are mixed into these runs. A behavioural model tracks every cycle, so the final wrap and the rise of `done_o` are compared exactly. A mid-run restart with `step_i` held high is then issued to check that the restart takes priority.

// File: rtl/cta_pkg.sv
package cta_pkg;

  typedef enum logic {
    MODE_DCACHE = 1'b0,
    MODE_ICACHE = 1'b1
  } tag_mode_e;

  // True when v is a nonzero power of two
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cta_step_counters.sv
module cta_step_counters
  import cta_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 512,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned TAG_W      = 5,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES),
  localparam int unsigned WRD_W     = $clog2(LINE_WORDS),
  localparam int unsigned ROT_W     = (TAG_W > 1) ? $clog2(TAG_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             mode_i,
  output logic [IDX_W-1:0] line_q,
  output logic [WRD_W-1:0] word_q,
  output logic [ROT_W-1:0] rot_q,
  output tag_mode_e        mode_q,
  output logic             done_q,
  output logic             adv_o,
  output logic             line_wrap_o,
  output logic             run_end_o
);

  logic line_last;
  logic word_last;
  logic rot_last;

  assign line_last   = (line_q == IDX_W'(NUM_LINES - 1));
  assign word_last   = (word_q == WRD_W'(LINE_WORDS - 1));
  assign rot_last    = (rot_q == ROT_W'(TAG_W - 1));
  assign adv_o       = step_i && !done_q && !start_i;
  assign line_wrap_o = adv_o && line_last;
  assign run_end_o   = line_wrap_o && word_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      word_q <= '0;
      rot_q  <= '0;
      mode_q <= MODE_DCACHE;
      done_q <= 1'b1;
    end else if (start_i) begin
      line_q <= '0;
      word_q <= '0;
      rot_q  <= '0;
      mode_q <= tag_mode_e'(mode_i);
      done_q <= 1'b0;
    end else if (adv_o) begin
      if (line_last) begin
        line_q <= '0;
        rot_q  <= '0;
        if (word_last) begin
          word_q <= '0;
          done_q <= 1'b1;
        end else begin
          word_q <= word_q + WRD_W'(1);
        end
      end else begin
        line_q <= line_q + IDX_W'(1);
        rot_q  <= rot_last ? '0 : rot_q + ROT_W'(1);
      end
    end
  end

endmodule

// File: rtl/cta_tag_pattern.sv
module cta_tag_pattern
  import cta_pkg::*;
#(
  parameter int unsigned TAG_W = 5,
  localparam int unsigned ROT_W = (TAG_W > 1) ? $clog2(TAG_W) : 1
) (
  input  logic [ROT_W-1:0] rot_i,
  input  tag_mode_e        mode_i,
  output logic [TAG_W-1:0] tag_o
);

  logic invert;
  assign invert = (mode_i == MODE_ICACHE);

  // Each bit is "selected" when the rotation pointer names it; the
  // instruction mode flips the whole field to march a zero instead.
  for (genvar b = 0; b < TAG_W; b++) begin : g_tag_bit
    logic hit;
    assign hit       = (rot_i == ROT_W'(b));
    assign tag_o[b]  = hit ^ invert;
  end

endmodule

// File: rtl/cta_addr_compose.sv
module cta_addr_compose #(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter int unsigned TAG_W       = 5,
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned WRD_W       = 2,
  parameter int unsigned TAG_LSB     = 13,
  parameter int unsigned IDX_LSB     = 4,
  parameter int unsigned WORD_LSB    = 2,
  localparam int unsigned SUM_W      = ((IDX_W > WRD_W) ? IDX_W : WRD_W) + 1
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  line_i,
  input  logic [WRD_W-1:0]  word_i,
  output logic [WRD_W-1:0]  skew_o,
  output logic [ADDR_W-1:0] addr_o
);

  // (line + word) mod words-per-line; power-of-two width makes it a slice
  function automatic logic [WRD_W-1:0] word_skew(input logic [IDX_W-1:0] ln,
                                                 input logic [WRD_W-1:0] wd);
    logic [SUM_W-1:0] s;
    s = SUM_W'(ln) + SUM_W'(wd);
    return s[WRD_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] place(input logic [ADDR_W-1:0] v,
                                             input int unsigned lsb);
    return v << lsb;
  endfunction

  logic [ADDR_W-1:0] tag_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] off_term;

  assign skew_o   = word_skew(line_i, word_i);
  assign tag_term = place(ADDR_W'(tag_i), TAG_LSB);
  assign idx_term = place(ADDR_W'(line_i), IDX_LSB);
  assign off_term = place(ADDR_W'(skew_o), WORD_LSB);
  assign addr_o   = BASE + tag_term + idx_term + off_term;

endmodule

// File: rtl/cache_test_addr_gen.sv
module cache_test_addr_gen
  import cta_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h1000_0000,
  parameter int unsigned CACHE_BYTES  = 8192,
  parameter int unsigned LINE_BYTES   = 16,
  parameter int unsigned WORD_BYTES   = 4,
  parameter int unsigned MEM_BYTES    = 262144,
  localparam int unsigned NUM_LINES   = CACHE_BYTES / LINE_BYTES,
  localparam int unsigned LINE_WORDS  = LINE_BYTES / WORD_BYTES,
  localparam int unsigned TAG_W       = $clog2(MEM_BYTES) - $clog2(CACHE_BYTES),
  localparam int unsigned IDX_W       = $clog2(NUM_LINES),
  localparam int unsigned WRD_W       = $clog2(LINE_WORDS),
  localparam int unsigned ROT_W       = (TAG_W > 1) ? $clog2(TAG_W) : 1,
  localparam int unsigned WORD_LSB    = $clog2(WORD_BYTES),
  localparam int unsigned IDX_LSB     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_LSB     = $clog2(CACHE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  initial begin
    if (!is_pow2(CACHE_BYTES) || !is_pow2(LINE_BYTES) ||
        !is_pow2(WORD_BYTES) || !is_pow2(MEM_BYTES))
      $error("cache_test_addr_gen: sizes must be powers of two");
    if (NUM_LINES < 2 || LINE_WORDS < 2 || MEM_BYTES <= CACHE_BYTES)
      $error("cache_test_addr_gen: geometry too small");
  end

  // Named internal events, brought out for the bound checker
  logic [IDX_W-1:0] line_q;
  logic [WRD_W-1:0] word_q;
  logic [ROT_W-1:0] rot_q;
  tag_mode_e        mode_q;
  logic             done_q;
  logic             adv_w;
  logic             line_wrap_w;
  logic             run_end_w;
  logic [TAG_W-1:0] tag_w;
  logic [WRD_W-1:0] skew_w;

  cta_step_counters #(
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS),
    .TAG_W     (TAG_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .step_i     (step_i),
    .mode_i     (mode_i),
    .line_q     (line_q),
    .word_q     (word_q),
    .rot_q      (rot_q),
    .mode_q     (mode_q),
    .done_q     (done_q),
    .adv_o      (adv_w),
    .line_wrap_o(line_wrap_w),
    .run_end_o  (run_end_w)
  );

  cta_tag_pattern #(
    .TAG_W(TAG_W)
  ) u_tag (
    .rot_i (rot_q),
    .mode_i(mode_q),
    .tag_o (tag_w)
  );

  cta_addr_compose #(
    .ADDR_W  (ADDR_W),
    .BASE    (BASE),
    .TAG_W   (TAG_W),
    .IDX_W   (IDX_W),
    .WRD_W   (WRD_W),
    .TAG_LSB (TAG_LSB),
    .IDX_LSB (IDX_LSB),
    .WORD_LSB(WORD_LSB)
  ) u_addr (
    .tag_i (tag_w),
    .line_i(line_q),
    .word_i(word_q),
    .skew_o(skew_w),
    .addr_o(addr_o)
  );

  assign done_o = done_q;

endmodule

// File: rtl/cta_checker.sv
module cta_checker
  import cta_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter int unsigned CACHE_BYTES = 8192,
  parameter int unsigned LINE_BYTES  = 16,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned MEM_BYTES   = 262144,
  localparam int unsigned NL   = CACHE_BYTES / LINE_BYTES,
  localparam int unsigned NW   = LINE_BYTES / WORD_BYTES,
  localparam int unsigned TW   = $clog2(MEM_BYTES) - $clog2(CACHE_BYTES),
  localparam int unsigned IW   = $clog2(NL),
  localparam int unsigned WW   = $clog2(NW),
  localparam int unsigned RW   = (TW > 1) ? $clog2(TW) : 1,
  localparam int unsigned OFFB = $clog2(LINE_BYTES),
  localparam int unsigned WSH  = $clog2(WORD_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              step_i,
  input logic [IW-1:0]     line_q,
  input logic [WW-1:0]     word_q,
  input logic [RW-1:0]     rot_q,
  input tag_mode_e         mode_q,
  input logic [TW-1:0]     tag_w,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  logic [ADDR_W-1:0] rel;
  logic [IW:0]       lsum;
  assign rel  = addr_o - BASE;
  assign lsum = (IW+1)'(line_q) + (IW+1)'(word_q);

  assert_index_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rel[OFFB +: IW] == line_q);

  assert_offset_skew_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel[WSH +: WW] == lsum[WW-1:0]);

  assert_rot_tracks_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rot_q) == (32'(line_q) % TW));

  assert_data_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DCACHE) |-> ($countones(tag_w) == 1 && tag_w[rot_q]));

  assert_inst_onecold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ICACHE) |-> ($countones(~tag_w) == 1 && !tag_w[rot_q]));

  assert_inner_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i && !done_o && line_q != IW'(NL - 1))
      |=> (line_q == $past(line_q) + IW'(1) && word_q == $past(word_q)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i && !done_o && line_q == IW'(NL - 1) && word_q == WW'(NW - 1))
      |=> (done_o && line_q == '0 && word_q == '0));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && line_q == '0 && word_q == '0));

  assert_ignore_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(addr_o)));

  assert_mode_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mode_q));

endmodule

bind cache_test_addr_gen cta_checker #(
  .ADDR_W     (ADDR_W),
  .BASE       (BASE),
  .CACHE_BYTES(CACHE_BYTES),
  .LINE_BYTES (LINE_BYTES),
  .WORD_BYTES (WORD_BYTES),
  .MEM_BYTES  (MEM_BYTES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .step_i (step_i),
  .line_q (line_q),
  .word_q (word_q),
  .rot_q  (rot_q),
  .mode_q (mode_q),
  .tag_w  (tag_w),
  .addr_o (addr_o),
  .done_o (done_o)
);

// File: tb/cache_test_addr_gen_test.sv
`timescale 1ns/1ps
module cache_test_addr_gen_test;

  localparam int          AW    = 32;
  localparam logic [31:0] BASEA = 32'h1000_0000;
  localparam int          CB    = 8192;
  localparam int          LB    = 16;
  localparam int          WB    = 4;
  localparam int          MB    = 262144;

  function automatic int lg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  localparam int NLINES = CB / LB;
  localparam int NWORDS = LB / WB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          step_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          done_o;

  always #2 clk = ~clk;

  cache_test_addr_gen #(
    .ADDR_W(AW), .BASE(BASEA), .CACHE_BYTES(CB), .LINE_BYTES(LB),
    .WORD_BYTES(WB), .MEM_BYTES(MB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .mode_i(mode_i), .addr_o(addr_o), .done_o(done_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int tagw;

  // Behavioural reference state
  int  m_ref = 0, n_ref = 0, md_ref = 0, acc_ref = 0;
  bit  done_ref = 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_tag(input int m, input int md);
    int one = 1 << (m % tagw);
    return (md == 0) ? one : (((1 << tagw) - 1) ^ one);
  endfunction

  function automatic longint exp_addr(input int m, input int n, input int md);
    longint a;
    a = BASEA;
    a += longint'(exp_tag(m, md)) << lg(CB);
    a += longint'(m) * LB;
    a += longint'((m + n) % NWORDS) * WB;
    return a & 64'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ref = 0; n_ref = 0; md_ref = 0; done_ref = 1'b1; acc_ref = 0;
    end else if (start_i) begin
      m_ref = 0; n_ref = 0; md_ref = int'(mode_i); done_ref = 1'b0; acc_ref = 0;
    end else if (step_i && !done_ref) begin
      acc_ref++;
      if (m_ref == NLINES - 1) begin
        m_ref = 0;
        if (n_ref == NWORDS - 1) begin n_ref = 0; done_ref = 1'b1; end
        else n_ref++;
      end else m_ref++;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      longint rel;
      rel = longint'(addr_o) - BASEA;
      chk(addr_o == 32'(exp_addr(m_ref, n_ref, md_ref)), "R2 address",
          addr_o, exp_addr(m_ref, n_ref, md_ref));
      chk(((rel >> lg(CB)) & ((1 << tagw) - 1)) == exp_tag(m_ref, md_ref),
          (md_ref == 0) ? "R3 one-hot tag" : "R4 one-cold tag",
          (rel >> lg(CB)) & ((1 << tagw) - 1), exp_tag(m_ref, md_ref));
      chk(((rel / LB) % NLINES) == m_ref, "R5 index",
          (rel / LB) % NLINES, m_ref);
      chk(((rel / WB) % NWORDS) == (m_ref + n_ref) % NWORDS, "R6 offset",
          (rel / WB) % NWORDS, (m_ref + n_ref) % NWORDS);
      chk(done_o == done_ref, "R8 done", done_o, done_ref);
    end
  end

  task automatic drive(input bit st, input bit sp, input bit md);
    @(negedge clk);
    start_i = st; step_i = sp; mode_i = md;
  endtask

  task automatic settle;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    tagw = lg(MB) - lg(CB);
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R11: reset state
    chk(done_o == 1'b1, "R11 done after reset", done_o, 1);
    chk(addr_o == BASEA + 32'h2000, "R11 address after reset", addr_o, BASEA + 32'h2000);

    // R10: steps before any start are ignored
    drive(0, 1, 1); drive(0, 1, 0); settle();
    chk(addr_o == BASEA + 32'h2000 && done_o, "R10 idle step ignored", addr_o, BASEA + 32'h2000);

    // Data-mode run; mode input toggled mid-run (R12)
    drive(1, 0, 0);
    drive(0, 1, 1);
    settle();
    chk(addr_o == BASEA + 32'h4014, "R1 geometry example point", addr_o, BASEA + 32'h4014);
    chk(tagw == 5 && NLINES == 512 && NWORDS == 4, "R1 derived geometry", tagw, 5);
    guard = 0;
    while (!done_o && guard < 4000) begin
      drive(0, (guard % 7) != 3, guard[0]);
      guard++;
      @(posedge clk); #1;
    end
    chk(acc_ref == NLINES * NWORDS, "R8 address count", acc_ref, NLINES * NWORDS);
    chk(done_o == 1'b1, "R8 done at end", done_o, 1);
    chk(((addr_o - BASEA) >> 13) == 32'h1, "R12 tag stayed data mode", (addr_o - BASEA) >> 13, 1);

    // R10: steps after completion ignored
    drive(0, 1, 0); drive(0, 1, 1); settle();
    chk(done_o && addr_o == BASEA + 32'h2000, "R10 post-done step ignored", addr_o, BASEA + 32'h2000);

    // Instruction mode, then restart with a simultaneous step (R9)
    drive(1, 0, 1);
    for (int i = 0; i < 700; i++) drive(0, 1, i[1]);
    drive(1, 1, 1);
    settle();
    chk(!done_o && addr_o == BASEA + (32'h1E << 13), "R9 restart beats step",
        addr_o, BASEA + (32'h1E << 13));
    // R7: next step moves line counter only
    drive(0, 1, 0); settle();
    chk(addr_o == BASEA + (32'h1D << 13) + 32'h10 + 32'h4, "R7 inner line advance",
        addr_o, BASEA + (32'h1D << 13) + 32'h14);
    guard = 0;
    while (!done_o && guard < 4000) begin
      drive(0, 1, 0);
      guard++;
      @(posedge clk); #1;
    end
    chk(done_o == 1'b1 && acc_ref == NLINES * NWORDS, "R8 instruction run length",
        acc_ref, NLINES * NWORDS);
    drive(0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule